// File: doc/BRIEF.md
# Traffic-Class to Virtual-Channel Egress Arbiter

This block sits at the egress side of one switch port that carries two virtual channels. Each virtual channel presents the packet at the head of its queue as a request line together with that packet's 3-bit traffic class. A per-port table assigns every traffic class to VC0 or VC1. A lane may compete only when the class of its head packet is mapped to that lane's own channel. The arbiter then picks one channel per cycle and raises a one-hot grant with a grant-valid strobe in the same cycle.

There are three arbitration policies, chosen by a mode input: strict priority (VC1 first), plain round robin, and weighted round robin with a 4-bit weight per channel. TC0 is pinned to VC0. A strap input turns VC1 off. While the strap is low, every class resolves to VC0, so VC1 never receives bandwidth. The table keeps its contents while VC1 is off and applies them again once the strap returns high.

Top module: `tcvc_arbiter`

## Requirements
- R1: After a synchronous active-low reset, every traffic class maps to VC0. The round-robin pointer treats VC1 as last granted. The weighted turn belongs to VC0 with zero grants used. With no request pending, `gnt` is 0 and `gnt_vld` is low.
- R2: With `map_wr` high at a clock edge, the table entry for class `map_wr_tc` becomes `map_wr_vc` (0 = VC0, 1 = VC1). The new entry is in effect from the next cycle. Lane i (bit i of `req_vld`, class in `req_tc[3*i+2:3*i]`) is eligible only when it is valid and its class resolves to channel i.
- R3: A table write that would move TC0 to VC1 is ignored, so TC0 keeps resolving to VC0.
- R4: While `vc1_en` is low, every class resolves to VC0 and `gnt[1]` is never raised. The table contents are kept.
- R5: `gnt` is one-hot or zero, a raised bit always belongs to a lane with a valid request, and `gnt_vld` equals the OR of `gnt`. Bit 0 of `gnt` is VC0 and bit 1 is VC1.
- R6: In strict mode (`arb_mode` 0, and code 3, which behaves the same), an eligible VC1 always wins over VC0.
- R7: In round-robin mode (`arb_mode` 1), when both lanes are eligible, the channel granted last loses. The last-granted channel is recorded on every grant, whatever the mode.
- R8: In weighted mode (`arb_mode` 2), the channel holding the turn takes up to its weight of consecutive grants while both lanes are eligible. The turn then passes to the other channel. VC0's weight is `vc_wt[3:0]` and VC1's is `vc_wt[7:4]`, and a weight of 0 counts as 1. The turn state advances on every grant, whatever the mode.
- R9: In weighted mode, if the channel holding the turn is not eligible, the other channel is granted. That grant forfeits the rest of the first channel's run, and the granted channel takes the turn with one grant used.
- R10: Whenever at least one lane is eligible, a grant is issued in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_mode | input | 2 | 0 strict, 1 round robin, 2 weighted, 3 strict |
| vc1_en | input | 1 | VC1 enable strap |
| vc_wt | input | 8 | Per-channel weights, VC0 in the low nibble |
| map_wr | input | 1 | Table write strobe |
| map_wr_tc | input | 3 | Traffic class being written |
| map_wr_vc | input | 1 | Channel assigned to that class |
| req_vld | input | 2 | Head-packet valid per channel lane |
| req_tc | input | 6 | Head-packet traffic class per lane, lane 0 low |
| gnt | output | 2 | One-hot grant per channel |
| gnt_vld | output | 1 | A grant is issued this cycle |

## Verification
The bench builds the block with its default parameters: eight traffic classes and 4-bit weights. Every weight from 0 (treated as one) up to fifteen consecutive grants is therefore reachable, as is every table entry, including the protected TC0 slot. The random phase regularly switches the strap, mode and weights while grant runs are in progress. This exercises pointer state carried across policies, forfeits in the middle of a run, and a remapping that moves a lane's class away from its own channel.

// File: rtl/tcvc_pkg.sv
// Shared definitions for the traffic-class to virtual-channel arbiter.
// Assumes exactly two virtual channels; the policy codes are a port encoding.
package tcvc_pkg;
    localparam int NUM_VC = 2;

    typedef enum logic [1:0] {
        ARB_STRICT     = 2'd0,
        ARB_RR         = 2'd1,
        ARB_WRR        = 2'd2,
        ARB_STRICT_ALT = 2'd3
    } arb_mode_e;
endpackage

// File: rtl/tcvc_map_table.sv
// Per-port class-to-channel table. One bit per traffic class (0 = VC0, 1 = VC1).
// Assumes NUM_TC fits in TC_W bits. Entry 0 is pinned to VC0; the strap forces
// every lookup to VC0 while VC1 is disabled, without disturbing stored entries.
module tcvc_map_table #(
    parameter int NUM_TC = 8,
    parameter int TC_W   = $clog2(NUM_TC),
    parameter int LANES  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TC_W-1:0]       wr_tc,
    input  logic                  wr_vc,
    input  logic                  vc1_en,
    input  logic [LANES*TC_W-1:0] lane_tc,
    output logic [LANES-1:0]      lane_vc,
    output logic                  tc0_vc
);
    logic [NUM_TC-1:0] tbl;

    for (genvar t = 0; t < NUM_TC; t++) begin : g_entry
        if (t == 0) begin : g_pinned
            // Purpose: class 0 never leaves VC0.
            always_ff @(posedge clk) begin
                tbl[t] <= 1'b0;
            end
        end else begin : g_prog
            // Purpose: load the entry on a write addressed to this class.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tbl[t] <= 1'b0;
                else if (wr_en && (wr_tc == TC_W'(t)))
                    tbl[t] <= wr_vc;
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lookup
        // Purpose: resolve a lane's head class, folded to VC0 when VC1 is off.
        always_comb begin
            lane_vc[l] = vc1_en & tbl[lane_tc[l*TC_W +: TC_W]];
        end
    end

    assign tc0_vc = tbl[0];
endmodule

// File: rtl/tcvc_sched_state.sv
// Arbitration history: last-granted channel for round robin, and turn owner
// plus grants used for weighted round robin. Assumes a single grant per cycle
// given by gnt_idx when gnt_vld is high. Weight 0 behaves as weight 1.
module tcvc_sched_state #(
    parameter int WT_W   = 4,
    parameter int NUM_VC = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   gnt_vld,
    input  logic                   gnt_idx,
    input  logic [NUM_VC*WT_W-1:0] vc_wt,
    output logic                   last_vc,
    output logic                   turn_vc
);
    localparam int CW = WT_W + 1;

    logic [CW-1:0]   used_q;
    logic [CW-1:0]   used_nx;
    logic [WT_W-1:0] raw_wt;
    logic [CW-1:0]   eff_wt;

    // Purpose: weight of the channel being granted, with zero lifted to one.
    always_comb begin
        raw_wt  = vc_wt[int'(gnt_idx)*WT_W +: WT_W];
        eff_wt  = (raw_wt == '0) ? CW'(1) : CW'(raw_wt);
        used_nx = (gnt_idx == turn_vc) ? used_q + CW'(1) : CW'(1);
    end

    // Purpose: record the last winner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_vc <= 1'b1;
        else if (gnt_vld)
            last_vc <= gnt_idx;
    end

    // Purpose: advance the weighted turn and its run counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            turn_vc <= 1'b0;
            used_q  <= '0;
        end else if (gnt_vld) begin
            if (used_nx >= eff_wt) begin
                turn_vc <= ~gnt_idx;
                used_q  <= '0;
            end else begin
                turn_vc <= gnt_idx;
                used_q  <= used_nx;
            end
        end
    end
endmodule

// File: rtl/tcvc_grant_sel.sv
// Combinational winner selection between two eligible channels under the
// chosen policy. Assumes eligibility already accounts for mapping and strap.
module tcvc_grant_sel
    import tcvc_pkg::*;
(
    input  logic [1:0] arb_mode,
    input  logic [1:0] elig,
    input  logic       last_vc,
    input  logic       turn_vc,
    output logic [1:0] gnt,
    output logic       gnt_idx
);
    logic both;

    // Purpose: pick the winning index and form the one-hot grant.
    always_comb begin
        both = &elig;
        unique case (arb_mode)
            ARB_RR:  gnt_idx = both ? ~last_vc : elig[1];
            ARB_WRR: gnt_idx = both ? turn_vc  : elig[1];
            default: gnt_idx = elig[1];
        endcase
        gnt = '0;
        if (|elig)
            gnt[gnt_idx] = 1'b1;
    end
endmodule

// File: rtl/tcvc_arbiter.sv
// Egress channel arbiter for one port. Each lane presents its channel's head
// packet class; a lane competes only when the class resolves to its own
// channel. One channel is granted per cycle, combinationally from the inputs
// and registered history. Assumes inputs are stable around the clock edge.
module tcvc_arbiter
    import tcvc_pkg::*;
#(
    parameter int NUM_TC = 8,
    parameter int WT_W   = 4,
    parameter int TC_W   = $clog2(NUM_TC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             arb_mode,
    input  logic                   vc1_en,
    input  logic [NUM_VC*WT_W-1:0] vc_wt,
    input  logic                   map_wr,
    input  logic [TC_W-1:0]        map_wr_tc,
    input  logic                   map_wr_vc,
    input  logic [NUM_VC-1:0]      req_vld,
    input  logic [NUM_VC*TC_W-1:0] req_tc,
    output logic [NUM_VC-1:0]      gnt,
    output logic                   gnt_vld
);
    logic [NUM_VC-1:0] lane_vc;
    logic [NUM_VC-1:0] elig;
    logic              tc0_vc;
    logic              last_vc;
    logic              turn_vc;
    logic              gnt_idx;

    tcvc_map_table #(.NUM_TC(NUM_TC), .TC_W(TC_W), .LANES(NUM_VC)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (map_wr),
        .wr_tc  (map_wr_tc),
        .wr_vc  (map_wr_vc),
        .vc1_en (vc1_en),
        .lane_tc(req_tc),
        .lane_vc(lane_vc),
        .tc0_vc (tc0_vc)
    );

    for (genvar v = 0; v < NUM_VC; v++) begin : g_elig
        // Purpose: a lane competes only when its class resolves to its channel.
        always_comb begin
            elig[v] = req_vld[v] && (lane_vc[v] == 1'(v));
        end
    end

    tcvc_grant_sel u_sel (
        .arb_mode(arb_mode),
        .elig    (elig),
        .last_vc (last_vc),
        .turn_vc (turn_vc),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    assign gnt_vld = |gnt;

    tcvc_sched_state #(.WT_W(WT_W), .NUM_VC(NUM_VC)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .gnt_vld(gnt_vld),
        .gnt_idx(gnt_idx),
        .vc_wt  (vc_wt),
        .last_vc(last_vc),
        .turn_vc(turn_vc)
    );
endmodule

// File: rtl/tcvc_checker.sv
// Property checker bound to the arbiter; observes ports and eligibility.
module tcvc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] arb_mode,
    input logic       vc1_en,
    input logic [1:0] req_vld,
    input logic [1:0] elig,
    input logic [1:0] gnt,
    input logic       gnt_vld,
    input logic       tc0_vc
);
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));                                                  // R5
    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req_vld) == 2'b00);                                      // R5
    AST_VC1_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !vc1_en |-> !gnt[1]);                                            // R4
    AST_TC0_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        !tc0_vc);                                                        // R3
    AST_STRICT_VC1: assert property (@(posedge clk) disable iff (!rst_n)
        ((arb_mode == 2'd0 || arb_mode == 2'd3) && elig[1]) |-> gnt[1]); // R6
    AST_RR_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_mode == 2'd1 && elig == 2'b11 && $past(rst_n)
         && $past(gnt_vld) && $past(gnt[0])) |-> gnt[1]);               // R7
    AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != 2'b00) |-> gnt_vld);                                    // R10
endmodule

bind tcvc_arbiter tcvc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .arb_mode(arb_mode),
    .vc1_en  (vc1_en),
    .req_vld (req_vld),
    .elig    (elig),
    .gnt     (gnt),
    .gnt_vld (gnt_vld),
    .tc0_vc  (tc0_vc)
);

// File: tb/tb_tcvc_arbiter.sv
module tb_tcvc_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int WT_W = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] arb_mode = 2'd0;
    logic       vc1_en = 1'b1;
    logic [7:0] vc_wt = 8'h11;
    logic       map_wr = 1'b0;
    logic [2:0] map_wr_tc = 3'd0;
    logic       map_wr_vc = 1'b0;
    logic [1:0] req_vld = 2'b00;
    logic [5:0] req_tc = 6'd0;
    logic [1:0] gnt;
    logic       gnt_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    bit m_tbl [8];
    bit m_last;
    bit m_turn;
    int m_used;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcvc_arbiter dut (
        .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode), .vc1_en(vc1_en),
        .vc_wt(vc_wt), .map_wr(map_wr), .map_wr_tc(map_wr_tc),
        .map_wr_vc(map_wr_vc), .req_vld(req_vld), .req_tc(req_tc),
        .gnt(gnt), .gnt_vld(gnt_vld)
    );

    function automatic bit lane_elig(int l);
        bit vc;
        vc = vc1_en && m_tbl[req_tc[l*3 +: 3]];
        return req_vld[l] && (int'(vc) == l);
    endfunction

    function automatic logic [1:0] exp_gnt();
        bit e0, e1;
        int w;
        e0 = lane_elig(0);
        e1 = lane_elig(1);
        if (!e0 && !e1) return 2'b00;
        if (e0 && e1) begin
            if (arb_mode == 2'd1) w = m_last ? 0 : 1;
            else if (arb_mode == 2'd2) w = int'(m_turn);
            else w = 1;
        end else w = e1 ? 1 : 0;
        return (w == 1) ? 2'b10 : 2'b01;
    endfunction

    function automatic string mode_tag();
        if (!vc1_en) return "R4";
        if (arb_mode == 2'd1) return "R7";
        if (arb_mode == 2'd2) return "R8";
        return "R6";
    endfunction

    task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got gnt_vld/gnt=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        foreach (m_tbl[i]) m_tbl[i] = 0;
        m_last = 1;
        m_turn = 0;
        m_used = 0;
    endtask

    // Called just after a negedge with inputs driven: check, then advance a cycle.
    task automatic step(string tag);
        logic [1:0] e;
        int g, w, un;
        #1;
        e = exp_gnt();
        check(tag, {gnt_vld, gnt}, {|e, e});
        @(posedge clk);
        if (map_wr && map_wr_tc != 3'd0) m_tbl[map_wr_tc] = map_wr_vc;
        if (|e) begin
            g = e[1] ? 1 : 0;
            m_last = bit'(g);
            w = int'(vc_wt[g*WT_W +: WT_W]);
            if (w == 0) w = 1;
            un = (g == int'(m_turn)) ? m_used + 1 : 1;
            if (un >= w) begin m_turn = ~bit'(g); m_used = 0; end
            else begin m_turn = bit'(g); m_used = un; end
        end
        @(negedge clk);
        map_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_vld = 2'b00;
        map_wr = 1'b0;
        @(posedge clk);
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 idle after reset", {gnt_vld, gnt}, 3'b000);
    endtask

    task automatic write_map(int tc, bit vc);
        map_wr = 1'b1; map_wr_tc = 3'(tc); map_wr_vc = vc;
        req_vld = 2'b00;
        step("R2 write cycle");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1: all classes start on VC0: lane0 with TC3 wins, lane1 with TC3 does not
        arb_mode = 2'd0; req_vld = 2'b11; req_tc = {3'd3, 3'd3};
        step("R1 default map");
        // R2: move TC5 to VC1, lane1 with TC5 becomes eligible and wins strictly (R6)
        write_map(5, 1'b1);
        req_vld = 2'b11; req_tc = {3'd5, 3'd0};
        step("R2 mapped class");
        n_chk++;
        if (gnt !== 2'b10) begin n_bad++; $display("FAIL R2: got %b expected 10", gnt); end
        // R2: lane0 with TC5 (now VC1) is not eligible
        req_vld = 2'b01; req_tc = {3'd0, 3'd5};
        step("R2 lane/class mismatch");
        // R3: attempt TC0 -> VC1, then lane1 with TC0 must not be granted
        write_map(0, 1'b1);
        req_vld = 2'b10; req_tc = {3'd0, 3'd0};
        step("R3 TC0 pinned");
        n_chk++;
        if (gnt_vld !== 1'b0) begin n_bad++; $display("FAIL R3: got %b expected 0", gnt_vld); end
        // R4: strap low folds TC5 to VC0, lane1 never granted
        vc1_en = 1'b0; req_vld = 2'b11; req_tc = {3'd5, 3'd5};
        step("R4 strap folds");
        // R4: table kept, strap high again restores VC1 for TC5
        vc1_en = 1'b1; req_vld = 2'b10;
        step("R4 table kept");
        // R7: round robin alternation, both eligible
        arb_mode = 2'd1; req_vld = 2'b11; req_tc = {3'd5, 3'd0};
        for (int i = 0; i < 4; i++) step("R7 alternation");
        // R8: weighted, VC0 weight 3, VC1 weight 1, fresh history
        do_reset();
        write_map(5, 1'b1);
        arb_mode = 2'd2; vc_wt = {4'd1, 4'd3}; req_vld = 2'b11; req_tc = {3'd5, 3'd0};
        for (int i = 0; i < 8; i++) step("R8 weighted runs");
        // R9: forfeit: turn owner drops out, other lane takes the turn
        vc_wt = {4'd3, 4'd3};
        req_vld = 2'b01; step("R9 forfeit setup");
        req_vld = 2'b10; step("R9 forfeit grant");
        req_vld = 2'b11;
        for (int i = 0; i < 4; i++) step("R9 after forfeit");
        // R8: weight zero counts as one
        vc_wt = {4'd0, 4'd0};
        for (int i = 0; i < 4; i++) step("R8 zero weight");

        // Random phase: R5 and R10 checked on every vector
        for (int c = 0; c < 6000; c++) begin
            if (c % 150 == 0) begin
                arb_mode = 2'($urandom_range(0, 3));
                vc1_en = ($urandom_range(0, 3) != 0);
                vc_wt = 8'($urandom);
            end
            if ($urandom_range(0, 15) == 0) begin
                map_wr = 1'b1;
                map_wr_tc = 3'($urandom);
                map_wr_vc = 1'($urandom);
            end
            req_vld = 2'($urandom);
            req_tc = 6'($urandom);
            step(mode_tag());
        end
        finish_run();
    end
endmodule